// File: doc/BRIEF.md
# Byte-Drained Sample FIFO

This block buffers 16-bit converter results so that a host with an 8-bit read path can collect them later. A result arrives as one pulse on `smp_valid` with the value on `smp_data`. It is stored as a byte pair and comes out low byte first, then high byte. The host removes one byte per read strobe. Two strobes, `rd_a` and `rd_b`, stand for two data addresses that alias to the same pop. The byte at the head of the queue is always visible on `rd_data`.

Several status outputs report the state of the queue. `empty` says whether any byte is present. `thr_flag` says whether the stored sample count has reached a selectable level. `overflow` latches when a result had to be discarded. A request line `irq` rises when the count reaches the threshold and stays high until the host acknowledges it. With `fifo_en` low the storage keeps only the most recent result. `fifo_reset` empties the queue and clears the latched flags.

Top module: `sample_byte_fifo`

## Requirements
- R1: Capacity is 2048 samples (4096 bytes). A sample that arrives while fewer than 2 bytes are free is discarded. In that case `overflow` sets and stays at 1 until `fifo_reset`.
- R2: Each accepted sample is queued as its bits 7:0 followed by its bits 15:8. `rd_data` shows the oldest byte one clock after the edge that stored or exposed it.
- R3: A pulse on `rd_a`, on `rd_b` or on both together removes exactly one byte.
- R4: A read while the queue is empty has no effect. `rd_data` is 0 while the queue is empty.
- R5: `empty` is 1 exactly when no byte is stored.
- R6: `thr_flag` is 1 while the stored byte count is at least 2048 (1024 samples) when `thr_sel`=0, or at least 512 (256 samples) when `thr_sel`=1.
- R7: `irq` goes to 1 at the edge after `thr_flag` changes from 0 to 1. It then holds until a clock edge with `irq_clr` high. A new crossing at that same edge keeps it at 1.
- R8: With `fifo_en`=0, a sample replaces the whole content: the queue then holds that sample's two bytes only, and a read in the same cycle is ignored.
- R9: A push and a pop in the same cycle both take effect: the head byte leaves and two bytes are appended.
- R10: `fifo_reset` empties the queue, clears `overflow` and `irq`, and takes priority over a push or pop in the same cycle.
- R11: After `rst_n` is released, the block shows `empty`=1, `overflow`=0, `irq`=0, `thr_flag`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle pulse marking a finished sample |
| smp_data | input | 16 | Sample value |
| fifo_en | input | 1 | 1: queued storage; 0: latest sample only |
| thr_sel | input | 1 | Threshold select: 0 half full, 1 one-eighth full |
| fifo_reset | input | 1 | Synchronous clear of content and latched flags |
| irq_clr | input | 1 | Acknowledge of the threshold request |
| rd_a | input | 1 | Read strobe, first data address |
| rd_b | input | 1 | Read strobe, aliased data address |
| rd_data | output | 8 | Oldest stored byte, 0 when empty |
| empty | output | 1 | No byte stored |
| thr_flag | output | 1 | Count at or above threshold |
| overflow | output | 1 | Sticky sample-dropped flag |
| irq | output | 1 | Threshold interrupt request |

## Verification
Pushes, pops and resets change the count and the head one clock edge after they are presented. `rd_data`, `empty` and `overflow` are therefore due one edge later. `thr_flag` is derived from the count without a register, so it follows the same edge and also follows `thr_sel` at once. `irq` is due one edge after `thr_flag` rises, which is two edges after the push that crossed the level. The bench drives inputs at the falling edge and updates its queue model at the rising edge. It compares every output at the next falling edge. The directed checks for the interrupt therefore insert one idle cycle before they sample.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // what a sample arrival does to the storage in a given cycle
    typedef enum logic [1:0] {
        ACT_NONE      = 2'd0,
        ACT_APPEND    = 2'd1,
        ACT_OVERWRITE = 2'd2,
        ACT_DROP      = 2'd3
    } push_act_e;

    function automatic logic [7:0] pick_byte(input logic [15:0] word, input logic hi);
        return hi ? word[15:8] : word[7:0];
    endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int SAMPLES = 2048,
    localparam int AW = $clog2(SAMPLES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);

    logic [15:0] mem_q [SAMPLES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int SAMPLES = 2048,
    localparam int AW    = $clog2(SAMPLES),
    localparam int BW    = AW + 1,
    localparam int CW    = AW + 2,
    localparam int BYTES = 2 * SAMPLES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [15:0]   sample,
    input  logic          en,
    input  logic          pop,
    input  logic          clr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [15:0]   wdata,
    output logic [AW-1:0] rword,
    output logic          rhi,
    output logic [CW-1:0] cnt,
    output logic          ovf
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [BW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovf;
    } st_t;

    st_t       st_d, st_q;
    push_act_e act;
    logic      do_pop;

    always_comb begin
        st_d   = st_q;
        act    = ACT_NONE;
        do_pop = 1'b0;
        if (push && !clr) begin
            if (!en) begin
                act = ACT_OVERWRITE;
            end else if (st_q.cnt > CW'(BYTES - 2)) begin
                act = ACT_DROP;
            end else begin
                act = ACT_APPEND;
            end
        end
        do_pop = pop && !clr && (st_q.cnt != '0) && (act != ACT_OVERWRITE);

        if (clr) begin
            st_d = '0;
        end else begin
            if (do_pop) begin
                st_d.rp = st_q.rp + BW'(1);
            end
            unique case (act)
                ACT_APPEND: begin
                    st_d.wp = st_q.wp + AW'(1);
                end
                ACT_OVERWRITE: begin
                    st_d.wp = AW'(1);
                    st_d.rp = '0;
                end
                ACT_DROP: begin
                    st_d.ovf = 1'b1;
                end
                default: ;
            endcase
            case (act)
                ACT_OVERWRITE: st_d.cnt = CW'(2);
                ACT_APPEND:    st_d.cnt = st_q.cnt + CW'(2) - CW'(do_pop);
                default:       st_d.cnt = st_q.cnt - CW'(do_pop);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign we    = (act == ACT_APPEND) || (act == ACT_OVERWRITE);
    assign waddr = (act == ACT_OVERWRITE) ? '0 : st_q.wp;
    assign wdata = sample;
    assign rword = st_q.rp[BW-1:1];
    assign rhi   = st_q.rp[0];
    assign cnt   = st_q.cnt;
    assign ovf   = st_q.ovf;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(BYTES)); // R1
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf && !clr |=> st_q.ovf); // R1
    AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        push && en && !clr && !pop && st_q.cnt > CW'(BYTES - 2) |=> st_q.cnt == $past(st_q.cnt) && st_q.ovf); // R1
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && !clr && st_q.cnt == '0 |=> st_q.cnt == '0); // R4
    AST_DISABLED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        push && !en && !clr |=> st_q.cnt == CW'(2)); // R8
    AST_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        push && en && pop && !clr && st_q.cnt != '0 && st_q.cnt <= CW'(BYTES - 2)
        |=> st_q.cnt == $past(st_q.cnt) + CW'(1)); // R9
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.cnt == '0 && !st_q.ovf); // R10

endmodule

// File: rtl/sfifo_irq.sv
module sfifo_irq #(
    parameter int SAMPLES = 2048,
    localparam int CW     = $clog2(SAMPLES) + 2,
    localparam int BYTES  = 2 * SAMPLES,
    localparam int THR_HALF   = BYTES / 2,
    localparam int THR_EIGHTH = BYTES / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          thr_sel,
    input  logic          irq_clr,
    input  logic          clr,
    output logic          thr_flag,
    output logic          irq
);

    typedef struct packed {
        logic prev;
        logic irq;
    } st_t;

    st_t  st_d, st_q;
    logic at_level;

    always_comb begin
        at_level = cnt >= (thr_sel ? CW'(THR_EIGHTH) : CW'(THR_HALF));
        st_d      = st_q;
        st_d.prev = at_level;
        if (clr) begin
            st_d.irq = 1'b0;
        end else if (at_level && !st_q.prev) begin
            st_d.irq = 1'b1;
        end else if (irq_clr) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign thr_flag = at_level;
    assign irq      = st_q.irq;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq && !irq_clr && !clr |=> st_q.irq); // R7
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        at_level && !st_q.prev && !clr |=> st_q.irq); // R7
    AST_IRQ_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !st_q.irq); // R10

endmodule

// File: rtl/sample_byte_fifo.sv
module sample_byte_fifo
    import sfifo_pkg::*;
#(
    parameter int SAMPLES = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_valid,
    input  logic [15:0] smp_data,
    input  logic        fifo_en,
    input  logic        thr_sel,
    input  logic        fifo_reset,
    input  logic        irq_clr,
    input  logic        rd_a,
    input  logic        rd_b,
    output logic [7:0]  rd_data,
    output logic        empty,
    output logic        thr_flag,
    output logic        overflow,
    output logic        irq
);

    localparam int AW = $clog2(SAMPLES);
    localparam int CW = AW + 2;

    logic          we;
    logic [AW-1:0] waddr;
    logic [15:0]   wdata;
    logic [AW-1:0] rword;
    logic          rhi;
    logic [CW-1:0] cnt;
    logic [15:0]   rword_data;
    logic          pop;

    assign pop = rd_a | rd_b;

    sfifo_ctrl #(.SAMPLES(SAMPLES)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (smp_valid),
        .sample (smp_data),
        .en     (fifo_en),
        .pop    (pop),
        .clr    (fifo_reset),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .rword  (rword),
        .rhi    (rhi),
        .cnt    (cnt),
        .ovf    (overflow)
    );

    sfifo_store #(.SAMPLES(SAMPLES)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (rword),
        .rdata (rword_data)
    );

    sfifo_irq #(.SAMPLES(SAMPLES)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .thr_sel  (thr_sel),
        .irq_clr  (irq_clr),
        .clr      (fifo_reset),
        .thr_flag (thr_flag),
        .irq      (irq)
    );

    assign empty   = (cnt == '0);
    assign rd_data = empty ? 8'h00 : pick_byte(rword_data, rhi);

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> rd_data == 8'h00); // R4
    AST_ALIAS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a && rd_b && !smp_valid && !fifo_reset && !empty |=> cnt == $past(cnt) - CW'(1)); // R3

endmodule

// File: tb/sim_sample_byte_fifo.sv
module sim_sample_byte_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        fifo_en = 1'b1;
    logic        thr_sel = 1'b0;
    logic        fifo_reset = 1'b0;
    logic        irq_clr = 1'b0;
    logic        rd_a = 1'b0;
    logic        rd_b = 1'b0;
    logic [7:0]  rd_data;
    logic        empty, thr_flag, overflow, irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] q[$];
    logic       m_ovf = 1'b0;
    logic       m_irq = 1'b0;
    logic       m_prev = 1'b0;

    always #2 clk = ~clk;

    sample_byte_fifo u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .fifo_en(fifo_en), .thr_sel(thr_sel), .fifo_reset(fifo_reset),
        .irq_clr(irq_clr), .rd_a(rd_a), .rd_b(rd_b), .rd_data(rd_data),
        .empty(empty), .thr_flag(thr_flag), .overflow(overflow), .irq(irq)
    );

    function automatic int thr_bytes(input logic sel);
        return sel ? 512 : 2048;
    endfunction

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_ovf = 0; m_irq = 0; m_prev = 0;
        end else begin
            int  old;
            logic f;
            old = q.size();
            f = (old >= thr_bytes(thr_sel));
            if (fifo_reset) m_irq = 0;
            else if (f && !m_prev) m_irq = 1;
            else if (irq_clr) m_irq = 0;
            m_prev = f;
            if (fifo_reset) begin
                q.delete(); m_ovf = 0;
            end else if (smp_valid && !fifo_en) begin
                q.delete();
                q.push_back(smp_data[7:0]);
                q.push_back(smp_data[15:8]);
            end else begin
                if ((rd_a || rd_b) && old > 0) void'(q.pop_front());
                if (smp_valid) begin
                    if (old > 4094) m_ovf = 1;
                    else begin
                        q.push_back(smp_data[7:0]);
                        q.push_back(smp_data[15:8]);
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R5 empty", empty, q.size() == 0);
        chk("R2 rd_data", rd_data, (q.size() == 0) ? 0 : q[0]);
        chk("R6 thr_flag", thr_flag, q.size() >= thr_bytes(thr_sel));
        chk("R1 overflow", overflow, m_ovf);
        chk("R7 irq", irq, m_irq);
    endtask

    // inputs applied at a falling edge, results compared at the next one
    task automatic step(input logic push, input logic [15:0] d, input logic ra,
                        input logic rb, input logic clr, input logic ack);
        smp_valid = push; smp_data = d; rd_a = ra; rd_b = rb;
        fifo_reset = clr; irq_clr = ack;
        @(posedge clk);
        @(negedge clk);
        smp_valid = 0; rd_a = 0; rd_b = 0; fifo_reset = 0; irq_clr = 0;
        compare_all();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 empty", empty, 1);
        chk("R11 overflow", overflow, 0);
        chk("R11 irq", irq, 0);
        chk("R11 thr_flag", thr_flag, 0);
        chk("R11 rd_data", rd_data, 0);

        // R2 byte order, R3 aliased reads
        step(1, 16'hA55A, 0, 0, 0, 0);
        step(1, 16'h1234, 0, 0, 0, 0);
        chk("R2 low first", rd_data, 8'h5A);
        step(0, 0, 1, 0, 0, 0);
        chk("R2 high next", rd_data, 8'hA5);
        step(0, 0, 0, 1, 0, 0);
        chk("R3 alias b", rd_data, 8'h34);
        step(0, 0, 1, 1, 0, 0);
        chk("R3 both one pop", rd_data, 8'h12);
        step(0, 0, 0, 1, 0, 0);
        chk("R5 drained", empty, 1);
        // R4 read on empty ignored
        step(0, 0, 1, 0, 0, 0);
        chk("R4 empty read", rd_data, 0);
        step(1, 16'hBEEF, 0, 0, 0, 0);
        chk("R4 pointers intact", rd_data, 8'hEF);

        // R9 push and pop together
        step(1, 16'h7788, 1, 0, 0, 0);
        chk("R9 head", rd_data, 8'hBE);
        step(0, 0, 1, 0, 0, 0);
        chk("R9 appended", rd_data, 8'h88);
        step(0, 0, 1, 0, 0, 0);
        chk("R9 appended hi", rd_data, 8'h77);
        step(0, 0, 1, 0, 0, 0);
        chk("R9 empty", empty, 1);

        // R8 disabled: latest sample only
        step(1, 16'h0102, 0, 0, 0, 0);
        fifo_en = 0;
        step(1, 16'h1122, 0, 0, 0, 0);
        step(1, 16'h3344, 1, 0, 0, 0);
        chk("R8 latest low", rd_data, 8'h44);
        step(0, 0, 1, 0, 0, 0);
        chk("R8 latest high", rd_data, 8'h33);
        step(0, 0, 1, 0, 0, 0);
        chk("R8 only one sample", empty, 1);
        fifo_en = 1;

        // R6 and R7 at one-eighth
        thr_sel = 1;
        for (int i = 0; i < 256; i++) step(1, 16'(i * 3 + 1), 0, 0, 0, 0);
        chk("R6 eighth reached", thr_flag, 1);
        chk("R7 not yet", irq, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R7 raised", irq, 1);
        step(0, 0, 0, 0, 0, 1);
        chk("R7 cleared", irq, 0);
        thr_sel = 0;
        step(0, 0, 0, 0, 0, 0);
        chk("R6 half not reached", thr_flag, 0);
        for (int i = 256; i < 1024; i++) step(1, 16'(i * 5 + 7), 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R7 half raised", irq, 1);

        // R1 fill and overflow
        for (int i = 1024; i < 2048; i++) step(1, 16'(i), 0, 0, 0, 0);
        chk("R1 full no ovf", overflow, 0);
        step(1, 16'hDEAD, 0, 0, 0, 0);
        chk("R1 ovf set", overflow, 1);
        step(1, 16'hCAFE, 1, 0, 0, 0);
        chk("R1 still dropped", overflow, 1);
        step(0, 0, 0, 0, 0, 0);
        chk("R1 sticky", overflow, 1);

        // R10 reset command beats a push
        step(1, 16'h5555, 1, 0, 1, 0);
        chk("R10 empty", empty, 1);
        chk("R10 ovf clear", overflow, 0);
        chk("R10 irq clear", irq, 0);
        step(1, 16'h9876, 0, 0, 0, 0);
        chk("R10 restart", rd_data, 8'h76);

        finish_run();
    end

endmodule